// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Thresholds

This block is a first-in first-out buffer for 36-bit words, with a write side and a read side that each run on their own clock. The two clocks may be unrelated, or they may be the same clock. Write and read pointers cross between the two clock domains as Gray codes through two-stage synchronizers. As a result, a flag that depends on the far side's activity updates a few cycles after that activity.

A master reset selects one of two timing modes, which stays fixed until the next master reset:

- **Standard mode.** The read side reports "data available". A requested word appears on `dout` one read clock after the request.
- **Fall-through mode.** The oldest word is placed on `dout` without any request. `rflag` then means "output valid", and a read request discards the word shown.

Two thresholds drive the almost-empty and almost-full outputs. The master reset also loads these thresholds, either from one of three preset values or by a programming sequence. That sequence takes the values either from the data bus or one bit at a time on a serial input. A partial reset empties the buffer but leaves the mode and thresholds untouched.

Top module: `prog_flag_fifo`

## Requirements
- R1: After either reset, with the default standard setup, `rflag` is 0, `wflag` is 1, `almost_empty` is 1 and `almost_full` is 0.
- R2: In standard mode, a read request sampled while `rflag` is 1 puts the oldest stored word on `dout` after that read clock edge. Words leave in write order, including between unrelated clocks. Each clock edge changes at most one bit of each crossing Gray pointer.
- R3: A write sampled while `wflag` is 0 is dropped and no pointer moves. `wflag` falls on the edge that stores the DEPTH-th word. The fill level never exceeds DEPTH.
- R4: In standard mode, a read request while `rflag` is 0 is ignored: `dout` holds and no later word is lost.
- R5: Fall-through mode is chosen by `fwft_sel`=1 during master reset. The first written word shows on `dout` with `rflag`=1 and no read request. It holds there until a read request is sampled with `rflag`=1.
- R6: On a shared clock, a write and a read on the same edge both take effect.
- R7: `almost_empty` is 1 when the stored count is at most the empty threshold. In fall-through mode, the stored count includes the word shown on `dout`.
- R8: `almost_full` is 1 when the free space (DEPTH minus words held in memory) is at most the full threshold.
- R9: During master reset, `cfg_sel` sets both thresholds to a preset: 0 gives 8, 1 gives 16 and 2 gives 64. The value 3 starts a programming sequence.
- R10: With `cfg_sel`=3 and `ser_mode`=0, the first two write-enabled clocks after master reset store nothing in the buffer. The first takes the empty threshold from `din[AW-1:0]` and the second takes the full threshold from the same bits. `wflag` stays 1 during this sequence.
- R11: With `cfg_sel`=3 and `ser_mode`=1, each write clock with `ser_en`=1 shifts in `ser_in`. 2·AW bits are taken, MSB first, empty threshold first and then full threshold. `wflag` is 0 until the last bit is taken, and writes in that span are dropped.
- R12: A partial reset empties the buffer but keeps the timing mode and both thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; configuration sampled on wclk/rclk edges while low |
| prst_n | input | 1 | Partial reset, active low |
| fwft_sel | input | 1 | Timing mode pick during master reset (1 = fall-through) |
| cfg_sel | input | 2 | Threshold source during master reset |
| ser_mode | input | 1 | Programming path when cfg_sel=3 (1 = serial) |
| wr_en | input | 1 | Write request |
| din | input | 36 | Write data |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial threshold bit |
| wflag | output | 1 | Room available (write accepted) |
| almost_full | output | 1 | Free space at or below full threshold |
| rd_en | input | 1 | Read request |
| dout | output | 36 | Read data |
| rflag | output | 1 | Standard: data stored; fall-through: dout valid |
| almost_empty | output | 1 | Stored count at or below empty threshold |

## Verification
On every cycle, the assertions check the following:

- a refused write leaves the write pointer still;
- the fill level stays within DEPTH;
- a read against an empty buffer in standard mode changes neither the pointer nor `dout`;
- a valid fall-through word holds while no read is requested;
- the crossing Gray pointers step one bit at a time.

Only the bench's scenarios can show the threshold boundaries for the three presets and for both programming paths. The same holds for retention across partial reset, same-edge read and write, and in-order delivery between unrelated clocks.

// File: rtl/prog_flag_fifo.sv
`timescale 1ns/1ps
module prog_flag_fifo #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int OFS_W = AW,
  localparam int PW    = $clog2(2*OFS_W+1)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              fwft_sel,
  input  logic [1:0]        cfg_sel,
  input  logic              ser_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  input  logic              ser_en,
  input  logic              ser_in,
  output logic              wflag,
  output logic              almost_full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] dout,
  output logic              rflag,
  output logic              almost_empty
);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW-1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rst_n;
  assign rst_n = mrst_n & prst_n;

  logic [DATA_W-1:0] mem [DEPTH];

  // write-side configuration
  logic             fwft_w;
  logic             prog_ser;
  logic [PW-1:0]    prog_left;
  logic [OFS_W-1:0] ae_ofs, af_ofs;
  logic             prog_busy;
  assign prog_busy = (prog_left != '0);

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      fwft_w   <= fwft_sel;
      prog_ser <= ser_mode;
      case (cfg_sel)
        2'd0:    begin ae_ofs <= OFS_W'(8);  af_ofs <= OFS_W'(8);  end
        2'd1:    begin ae_ofs <= OFS_W'(16); af_ofs <= OFS_W'(16); end
        2'd2:    begin ae_ofs <= OFS_W'(64); af_ofs <= OFS_W'(64); end
        default: begin ae_ofs <= '0;         af_ofs <= '0;         end
      endcase
      prog_left <= (cfg_sel == 2'd3) ? (ser_mode ? PW'(2*OFS_W) : PW'(2)) : '0;
    end else if (prog_busy) begin
      if (prog_ser && ser_en) begin
        {ae_ofs, af_ofs} <= {ae_ofs[OFS_W-2:0], af_ofs, ser_in};
        prog_left        <= prog_left - 1'b1;
      end else if (!prog_ser && wr_en) begin
        if (prog_left == PW'(2)) ae_ofs <= din[OFS_W-1:0];
        else                     af_ofs <= din[OFS_W-1:0];
        prog_left <= prog_left - 1'b1;
      end
    end
  end

  // write domain
  logic [AW:0] wptr, wgray, rq1, rq2, rq2_bin, wcount, wfree;
  logic        full, wr_go;

  assign rq2_bin = g2b(rq2);
  assign wcount  = wptr - rq2_bin;
  assign full    = (wcount == (AW+1)'(DEPTH));
  assign wfree   = (AW+1)'(DEPTH) - wcount;
  assign wr_go   = wr_en && !prog_busy && !full;
  assign wflag   = prog_busy ? !prog_ser : !full;
  assign almost_full = (wfree <= {1'b0, af_ofs});

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_go) begin
        wptr  <= wptr + 1'b1;
        wgray <= (wptr + 1'b1) ^ ((wptr + 1'b1) >> 1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wptr[AW-1:0]] <= din;
  end

  // read domain
  logic              fwft_r;
  logic [AW:0]       rptr, rgray, wq1, wq2, wq2_bin;
  logic              mem_empty, ovalid, take;
  logic [DATA_W-1:0] dout_q;
  logic [AW+1:0]     rcount;

  always_ff @(posedge rclk) begin
    if (!mrst_n) fwft_r <= fwft_sel;
  end

  assign wq2_bin   = g2b(wq2);
  assign mem_empty = (rptr == wq2_bin);
  assign take      = fwft_r ? (!mem_empty && (!ovalid || rd_en))
                            : (rd_en && !mem_empty);
  assign rflag     = fwft_r ? ovalid : !mem_empty;
  assign dout      = dout_q;
  assign rcount    = {1'b0, wq2_bin - rptr} + {{(AW+1){1'b0}}, fwft_r & ovalid};
  assign almost_empty = (rcount <= {2'b00, ae_ofs});

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      rgray  <= '0;
      wq1    <= '0;
      wq2    <= '0;
      ovalid <= 1'b0;
      dout_q <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (take) begin
        rptr   <= rptr + 1'b1;
        rgray  <= (rptr + 1'b1) ^ ((rptr + 1'b1) >> 1);
        dout_q <= mem[rptr[AW-1:0]];
      end
      if (fwft_r) ovalid <= take || (ovalid && !rd_en);
      else        ovalid <= 1'b0;
    end
  end

  logic unused_cfg;
  assign unused_cfg = fwft_w;

endmodule

// File: rtl/prog_flag_fifo_chk.sv
`timescale 1ns/1ps
module prog_flag_fifo_chk #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              wflag,
  input logic              rflag,
  input logic              rd_en,
  input logic              fwft_r,
  input logic [DATA_W-1:0] dout,
  input logic [AW:0]       wptr,
  input logic [AW:0]       rptr,
  input logic [AW:0]       wgray,
  input logic [AW:0]       rgray,
  input logic [AW:0]       rq2_bin
);
  logic [AW:0] fill;
  assign fill = wptr - rq2_bin;

  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH));

  // R3
  blocked_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !wflag |=> $stable(wptr));

  // R4
  empty_read_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft_r && !rflag) |=> ($stable(rptr) && $stable(dout)));

  // R5
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft_r && rflag && !rd_en) |=> (rflag && $stable(dout)));

  // R2
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));

  // R2
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));
endmodule

bind prog_flag_fifo prog_flag_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wflag(wflag), .rflag(rflag),
  .rd_en(rd_en), .fwft_r(fwft_r), .dout(dout), .wptr(wptr), .rptr(rptr),
  .wgray(wgray), .rgray(rgray), .rq2_bin(rq2_bin)
);

// File: tb/test_prog_flag_fifo.sv
`timescale 1ns/1ps
module test_prog_flag_fifo;
  localparam int CLK_PERIOD = 10;
  localparam realtime RHALF = CLK_PERIOD * 0.65;
  localparam int DEPTH = 256;
  localparam int DW = 36;
  localparam int NRAND = 1500;

  logic wclk = 0, rclk_free = 0, coinc = 1;
  logic rclk;
  assign rclk = coinc ? wclk : rclk_free;
  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RHALF) rclk_free = ~rclk_free;

  logic mrst_n = 0, prst_n = 1, fwft_sel = 0, ser_mode = 0;
  logic [1:0] cfg_sel = 0;
  logic wr_en = 0, rd_en = 0, ser_en = 0, ser_in = 0;
  logic [DW-1:0] din = 0;
  logic wflag, almost_full, rflag, almost_empty;
  logic [DW-1:0] dout;

  prog_flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_prog_flag_fifo (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .cfg_sel(cfg_sel), .ser_mode(ser_mode),
    .wr_en(wr_en), .din(din), .ser_en(ser_en), .ser_in(ser_in),
    .wflag(wflag), .almost_full(almost_full), .rd_en(rd_en), .dout(dout),
    .rflag(rflag), .almost_empty(almost_empty));

  int checks = 0, fails = 0;
  logic [DW-1:0] q[$];

  function automatic bit exp_ae(int cnt, int ofs); return cnt <= ofs; endfunction
  function automatic bit exp_af(int cnt, int ofs); return (DEPTH - cnt) <= ofs; endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic idle(int n); repeat (n) @(negedge wclk); endtask

  task automatic mreset(bit fw, logic [1:0] sel, bit ser);
    @(negedge wclk);
    mrst_n = 0; fwft_sel = fw; cfg_sel = sel; ser_mode = ser;
    wr_en = 0; rd_en = 0; ser_en = 0;
    repeat (3) @(negedge wclk);
    mrst_n = 1; q.delete();
    idle(1);
  endtask

  task automatic preset();
    prst_n = 0; idle(2); prst_n = 1; q.delete(); idle(1);
  endtask

  task automatic push(logic [DW-1:0] d);
    wr_en = 1; din = d;
    if (wflag) q.push_back(d);
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic push_n(int n, int base);
    for (int k = 0; k < n; k++) push(DW'(base + k));
  endtask

  task automatic pop_std(string req);
    logic [DW-1:0] prev, e;
    bit was;
    prev = dout; was = rflag; rd_en = 1;
    @(negedge wclk); rd_en = 0;
    if (was) begin e = q.pop_front(); chk(dout == e, req, dout, e); end
    else chk(dout == prev, req, dout, prev);
  endtask

  task automatic pop_fwft(string req);
    logic [DW-1:0] e;
    if (rflag) begin e = q.pop_front(); chk(dout == e, req, dout, e); end
    rd_en = 1; @(negedge wclk); rd_en = 0;
  endtask

  task automatic rand_phase(bit fw);
    coinc = 0;
    mreset(fw, 2'd0, 0);
    fork
      begin
        int wn = 0;
        while (wn < NRAND) begin
          @(negedge wclk);
          wr_en = ($urandom % 3) != 0;
          din = {4'($urandom), 32'($urandom)};
          if (wr_en && wflag) begin q.push_back(din); wn++; end
        end
        @(negedge wclk); wr_en = 0;
      end
      begin
        int rn = 0;
        bit pend = 0;
        logic [DW-1:0] e = 0;
        while (rn < NRAND) begin
          @(negedge rclk);
          if (!fw) begin
            if (pend) begin chk(dout == e, "R2 async order", dout, e); rn++; end
            rd_en = ($urandom % 3) != 0;
            pend = rd_en && rflag;
            if (pend) e = q.pop_front();
          end else begin
            rd_en = ($urandom % 3) != 0;
            if (rd_en && rflag) begin
              e = q.pop_front(); chk(dout == e, "R5 async order", dout, e); rn++;
            end
          end
        end
        @(negedge rclk); rd_en = 0;
      end
    join
    mreset(0, 2'd0, 0);
    coinc = 1;
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    void'($urandom(32'h5eed_0001));
    // R1 reset state
    mreset(0, 2'd0, 0);
    chk(rflag == 0, "R1 rflag", rflag, 0);
    chk(wflag == 1, "R1 wflag", wflag, 1);
    chk(almost_empty == 1, "R1 almost_empty", almost_empty, 1);
    chk(almost_full == 0, "R1 almost_full", almost_full, 0);

    // R7 default threshold 8 and R2 ordered reads
    push_n(8, 36'h100); idle(4);
    chk(almost_empty == exp_ae(8, 8), "R7 ae at 8", almost_empty, 1);
    push(36'h1ff); idle(4);
    chk(almost_empty == exp_ae(9, 8), "R7 ae at 9", almost_empty, 0);
    chk(rflag == 1, "R2 rflag set", rflag, 1);
    for (int k = 0; k < 9; k++) pop_std("R2 order");
    idle(4);
    chk(rflag == 0, "R2 drained", rflag, 0);
    pop_std("R4 empty read");
    chk(rflag == 0, "R4 rflag", rflag, 0);

    // R3, R8 fill to the brim
    mreset(0, 2'd0, 0);
    for (int k = 1; k <= DEPTH; k++) begin
      push(DW'(36'hA_0000_0000 + k));
      if (k == DEPTH-9) chk(almost_full == exp_af(k, 8), "R8 af below", almost_full, 0);
      if (k == DEPTH-8) chk(almost_full == exp_af(k, 8), "R8 af at", almost_full, 1);
    end
    chk(wflag == 0, "R3 full", wflag, 0);
    push(36'hDEAD);
    idle(4);
    for (int k = 0; k < DEPTH; k++) pop_std("R3 contents");
    idle(4);
    chk(rflag == 0, "R3 extra dropped", rflag, 0);
    pop_std("R4 empty read held");
    push(36'h77); idle(4);
    pop_std("R4 no loss");

    // R6 same-edge read and write
    push_n(3, 36'h300); idle(4);
    for (int k = 0; k < 6; k++) begin
      logic [DW-1:0] e;
      wr_en = 1; rd_en = 1; din = DW'(36'h400 + k);
      q.push_back(din); e = q.pop_front();
      @(negedge wclk); wr_en = 0; rd_en = 0;
      chk(dout == e, "R6 same edge data", dout, e);
    end
    idle(4);
    chk(q.size() == 3, "R6 count", DW'(q.size()), 3);
    for (int k = 0; k < 3; k++) pop_std("R6 drain");
    idle(4);
    chk(rflag == 0, "R6 empty after drain", rflag, 0);

    // R9 presets
    for (int s = 0; s < 3; s++) begin
      int ofs;
      ofs = (s == 0) ? 8 : (s == 1) ? 16 : 64;
      mreset(0, 2'(s), 0);
      push_n(ofs, 36'h500); idle(4);
      chk(almost_empty == exp_ae(ofs, ofs), "R9 preset at", almost_empty, 1);
      push(36'h5ff); idle(4);
      chk(almost_empty == exp_ae(ofs+1, ofs), "R9 preset above", almost_empty, 0);
    end

    // R10 parallel programming: ae=5, af=200
    mreset(0, 2'd3, 0);
    chk(wflag == 1, "R10 wflag while loading", wflag, 1);
    wr_en = 1; din = 36'd5;   @(negedge wclk);
    din = 36'd200; @(negedge wclk); wr_en = 0;
    idle(4);
    chk(rflag == 0, "R10 config words not stored", rflag, 0);
    push_n(5, 36'h600); idle(4);
    chk(almost_empty == exp_ae(5, 5), "R10 ae at 5", almost_empty, 1);
    push(36'h6ff); idle(4);
    chk(almost_empty == exp_ae(6, 5), "R10 ae at 6", almost_empty, 0);
    push_n(49, 36'h700);
    chk(almost_full == exp_af(55, 200), "R10 af at 55", almost_full, 0);
    push(36'h7ff);
    chk(almost_full == exp_af(56, 200), "R10 af at 56", almost_full, 1);

    // R12 partial reset keeps thresholds
    preset();
    chk(rflag == 0, "R12 emptied", rflag, 0);
    chk(almost_empty == 1, "R12 ae after", almost_empty, 1);
    chk(wflag == 1, "R12 wflag", wflag, 1);
    push_n(5, 36'h800); idle(4);
    chk(almost_empty == exp_ae(5, 5), "R12 ae kept", almost_empty, 1);
    push(36'h8ff); idle(4);
    chk(almost_empty == exp_ae(6, 5), "R12 ae kept above", almost_empty, 0);
    push_n(50, 36'h900);
    chk(almost_full == exp_af(56, 200), "R12 af kept", almost_full, 1);

    // R11 serial programming: ae=3, af=10
    mreset(0, 2'd3, 1);
    chk(wflag == 0, "R11 wflag low", wflag, 0);
    begin
      logic [15:0] bits;
      bits = {8'd3, 8'd10};
      for (int i = 15; i >= 0; i--) begin
        ser_en = 1; ser_in = bits[i]; wr_en = 1; din = 36'hABC;
        if (i == 0) chk(wflag == 0, "R11 wflag before last bit", wflag, 0);
        @(negedge wclk);
      end
      ser_en = 0; wr_en = 0;
    end
    chk(wflag == 1, "R11 wflag after load", wflag, 1);
    idle(4);
    chk(rflag == 0, "R11 writes dropped", rflag, 0);
    push_n(3, 36'hB00); idle(4);
    chk(almost_empty == exp_ae(3, 3), "R11 ae at 3", almost_empty, 1);
    push(36'hBFF); idle(4);
    chk(almost_empty == exp_ae(4, 3), "R11 ae at 4", almost_empty, 0);
    push_n(241, 36'hC00);
    chk(almost_full == exp_af(245, 10), "R11 af at 245", almost_full, 0);
    push(36'hCFF);
    chk(almost_full == exp_af(246, 10), "R11 af at 246", almost_full, 1);

    // R5 fall-through
    mreset(1, 2'd0, 0);
    chk(rflag == 0, "R1 fwft rflag", rflag, 0);
    push(36'hF_1234_5678); idle(4);
    chk(rflag == 1, "R5 first word valid", rflag, 1);
    chk(dout == 36'hF_1234_5678, "R5 first word shown", dout, 36'hF_1234_5678);
    idle(3);
    chk(dout == 36'hF_1234_5678, "R5 word held", dout, 36'hF_1234_5678);
    push(36'hE1); push(36'hE2); idle(4);
    chk(almost_empty == exp_ae(3, 8), "R7 fwft ae", almost_empty, 1);
    for (int k = 0; k < 3; k++) pop_fwft("R5 pop order");
    idle(2);
    chk(rflag == 0, "R5 empty", rflag, 0);
    push_n(9, 36'hD00); idle(5);
    chk(almost_empty == exp_ae(9, 8), "R7 fwft count 9", almost_empty, 0);
    pop_fwft("R5 pop"); idle(4);
    chk(almost_empty == exp_ae(8, 8), "R7 fwft count 8", almost_empty, 1);

    // unrelated clocks
    rand_phase(0);
    rand_phase(1);

    report();
  end
endmodule